// File: doc/BRIEF.md
# Destination Address Filter with Multicast Hash

The block decides whether an incoming Ethernet frame is for this station. The 48-bit destination address arrives one bit per accepted cycle, least significant bit first, after a start-of-frame strobe. Unicast addresses are compared byte by byte against a six-byte station address. In parallel, every address bit passes through a serial CRC-32 generator. The top six CRC bits left after the final bit pick one bit of a 64-bit multicast filter.

One cycle after the last address bit, the block pulses a valid strobe. It presents a registered accept flag and a registered multicast flag, and both hold until the next start-of-frame. Software loads the station bytes and the filter bytes through a simple byte-wide write port.

Top module: `addr_filter`

## Requirements
- R1: After reset, dec_vld, dec_accept and dec_mcast are 0, and all station and filter bytes are 0.
- R2: A write with cfg_addr k in 0..5 loads station byte k, which holds address bits DA(8k+7)..DA(8k). A write with cfg_addr 8+m, for m in 0..7, loads filter byte m, which holds filter bit n = 8m+i at bit i. Writes to addresses 6 and 7 change nothing.
- R3: sof starts a new address. A bit offered in the same cycle as sof is ignored. On the edge that takes sof, dec_accept and dec_mcast clear to 0.
- R4: The first bit taken after sof is DA0. A 1 marks the address as multicast, and dec_mcast reports this value with the decision.
- R5: When DA0 is 0, the frame is accepted only if all six address bytes equal the six station bytes. A mismatch in any single byte rejects the frame.
- R6: When DA0 is 1, a 32-bit CRC is preset to all ones at sof. For each address bit d, with f = crc[31] XOR d, the CRC becomes (crc shifted left by one) XOR (f ? 0x04C11DB7 : 0). After DA47, n = crc[31:26], and the frame is accepted exactly when filter bit n is 1.
- R7: dec_vld is high for exactly one cycle, in the cycle after the edge that takes DA47. dec_accept and dec_mcast are valid in that cycle.
- R8: dec_accept and dec_mcast hold their values until the next sof. Bits offered after DA47 have no effect.
- R9: With all 64 filter bits set, every multicast address is accepted.
- R10: Cycles with bit_vld low are skipped and do not advance the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof | input | 1 | Start-of-address strobe |
| bit_vld | input | 1 | bit_in carries an address bit this cycle |
| bit_in | input | 1 | Serial destination address bit, LSB first |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 4 | Register select |
| cfg_wdata | input | 8 | Register write data |
| dec_vld | output | 1 | One-cycle decision strobe |
| dec_accept | output | 1 | Frame accepted |
| dec_mcast | output | 1 | Address was multicast (DA0) |

## Verification
The bench targets the following corner cases, each chosen because a specific design error would show up in it:
- Single-byte mismatches at every byte position. A design that skips a byte compare, or indexes the station bytes off by one, accepts some of these frames.
- Multicast addresses checked against a filter with only the expected bit set, and then against a filter with only the neighbouring bit set. A wrong CRC preset, polynomial, shift direction or capture point selects the wrong bit.
- A bit offered alongside sof, bits offered after DA47, and long idle gaps between bits. These cases catch a bit counter that miscounts, and a decision that drifts after it has been made.

// File: rtl/af_pkg.sv
package af_pkg;
  localparam int unsigned CRC_W   = 32;
  localparam int unsigned HASH_W  = 6;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7;
  localparam logic [CRC_W-1:0] CRC_SEED = '1;

  // One serial step of the hashing CRC, MSB-side feedback.
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic d);
    logic fb;
    fb = c[CRC_W-1] ^ d;
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction

  // Filter index taken from the top of the CRC.
  function automatic logic [HASH_W-1:0] hash_of(input logic [CRC_W-1:0] c);
    return c[CRC_W-1 -: HASH_W];
  endfunction
endpackage

// File: rtl/af_regs.sv
module af_regs #(
  parameter int unsigned NB    = 6,
  parameter int unsigned HB    = 8,
  parameter int unsigned AW    = 4,
  parameter int unsigned HBASE = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [AW-1:0]   addr,
  input  logic [7:0]      wdata,
  output logic [8*NB-1:0] station_o,
  output logic [8*HB-1:0] filter_o
);
  for (genvar g = 0; g < NB; g++) begin : g_sta
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else if (we && addr == AW'(g)) q <= wdata;
    end
    assign station_o[8*g +: 8] = q;
  end

  for (genvar g = 0; g < HB; g++) begin : g_flt
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else if (we && addr == AW'(HBASE + g)) q <= wdata;
    end
    assign filter_o[8*g +: 8] = q;
  end
endmodule

// File: rtl/af_crc_hash.sv
module af_crc_hash
  import af_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              take,
  input  logic              din,
  output logic [HASH_W-1:0] hash_o
);
  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] crc_nxt;

  assign crc_nxt = crc_step(crc_q, din);
  // Index as the current bit enters; sampled by the top on the last bit.
  assign hash_o  = hash_of(crc_nxt);

  always_ff @(posedge clk) begin
    if (!rst_n)     crc_q <= CRC_SEED;
    else if (start) crc_q <= CRC_SEED;
    else if (take)  crc_q <= crc_nxt;
  end
endmodule

// File: rtl/af_match.sv
module af_match #(
  parameter int unsigned NB = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sof,
  input  logic            bit_vld,
  input  logic            bit_in,
  input  logic [8*NB-1:0] station,
  output logic            take,
  output logic            last_bit,
  output logic            byte_done,
  output logic            uni_ok,
  output logic            mcast_flag
);
  localparam int unsigned ABITS = 8 * NB;
  localparam int unsigned CW    = $clog2(ABITS);
  localparam int unsigned IW    = CW - 3;

  logic          active;
  logic [CW-1:0] cnt;
  logic [7:0]    sr;
  logic          mismatch;
  logic [7:0]    cur_byte;
  logic [IW-1:0] byte_idx;
  logic          byte_ok;

  assign take      = active && bit_vld && !sof;
  assign last_bit  = take && (cnt == CW'(ABITS - 1));
  assign byte_done = take && (cnt[2:0] == 3'b111);
  assign byte_idx  = cnt[CW-1:3];
  assign cur_byte  = {bit_in, sr[7:1]};
  assign byte_ok   = (cur_byte == station[{byte_idx, 3'b000} +: 8]);
  assign uni_ok    = !mismatch && byte_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active     <= 1'b0;
      cnt        <= '0;
      sr         <= '0;
      mismatch   <= 1'b0;
      mcast_flag <= 1'b0;
    end else if (sof) begin
      active     <= 1'b1;
      cnt        <= '0;
      mismatch   <= 1'b0;
      mcast_flag <= 1'b0;
    end else if (take) begin
      sr  <= cur_byte;
      cnt <= cnt + 1'b1;
      if (cnt == '0) mcast_flag <= bit_in;
      if (byte_done && !byte_ok) mismatch <= 1'b1;
      if (last_bit) active <= 1'b0;
    end
  end
endmodule

// File: rtl/addr_filter.sv
module addr_filter
  import af_pkg::*;
#(
  parameter int unsigned NB = 6,
  parameter int unsigned AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sof,
  input  logic          bit_vld,
  input  logic          bit_in,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [7:0]    cfg_wdata,
  output logic          dec_vld,
  output logic          dec_accept,
  output logic          dec_mcast
);
  localparam int unsigned FBITS = 1 << HASH_W;
  localparam int unsigned HB    = FBITS / 8;

  logic [8*NB-1:0]   station;
  logic [FBITS-1:0]  filter;
  logic              take, last_bit, byte_done, uni_ok, mcast_flag;
  logic [HASH_W-1:0] hash_idx;
  logic              hash_hit;

  af_regs #(.NB(NB), .HB(HB), .AW(AW), .HBASE(8)) regs_i (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .station_o(station), .filter_o(filter)
  );

  af_match #(.NB(NB)) match_i (
    .clk(clk), .rst_n(rst_n), .sof(sof), .bit_vld(bit_vld), .bit_in(bit_in),
    .station(station), .take(take), .last_bit(last_bit), .byte_done(byte_done),
    .uni_ok(uni_ok), .mcast_flag(mcast_flag)
  );

  af_crc_hash crc_i (
    .clk(clk), .rst_n(rst_n), .start(sof), .take(take), .din(bit_in), .hash_o(hash_idx)
  );

  assign hash_hit = filter[hash_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_vld    <= 1'b0;
      dec_accept <= 1'b0;
      dec_mcast  <= 1'b0;
    end else begin
      dec_vld <= last_bit;
      if (sof) begin
        dec_accept <= 1'b0;
        dec_mcast  <= 1'b0;
      end else if (last_bit) begin
        dec_accept <= mcast_flag ? hash_hit : uni_ok;
        dec_mcast  <= mcast_flag;
      end
    end
  end
endmodule

// File: rtl/af_checker.sv
module af_checker #(
  parameter int unsigned FBITS = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sof,
  input logic             take,
  input logic             last_bit,
  input logic             byte_done,
  input logic             mcast_flag,
  input logic [FBITS-1:0] filter,
  input logic             dec_vld,
  input logic             dec_accept,
  input logic             dec_mcast
);
  AST_VLD_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n) last_bit |=> dec_vld); // R7
  AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) dec_vld |=> !dec_vld); // R7
  AST_VLD_NEEDS_LAST: assert property (@(posedge clk) disable iff (!rst_n) dec_vld |-> $past(last_bit)); // R7
  AST_SOF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) sof |=> (!dec_accept && !dec_mcast)); // R3
  AST_DECISION_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (!sof && !last_bit) |=> ($stable(dec_accept) && $stable(dec_mcast))); // R8
  AST_ALL_ONES_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) (last_bit && mcast_flag && (&filter)) |=> dec_accept); // R9
  AST_BYTE_NEEDS_TAKE: assert property (@(posedge clk) disable iff (!rst_n) byte_done |-> take); // R10
  AST_SOF_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n) sof |-> !take); // R3
endmodule

bind addr_filter af_checker #(.FBITS(FBITS)) chk_i (
  .clk(clk), .rst_n(rst_n), .sof(sof), .take(take), .last_bit(last_bit),
  .byte_done(byte_done), .mcast_flag(mcast_flag), .filter(filter),
  .dec_vld(dec_vld), .dec_accept(dec_accept), .dec_mcast(dec_mcast)
);

// File: tb/addr_filter_tb_top.sv
`timescale 1ns/1ps
module addr_filter_tb_top;
  logic clk = 0, rst_n = 0, sof = 0, bit_vld = 0, bit_in = 0, cfg_we = 0;
  logic [3:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic dec_vld, dec_accept, dec_mcast;

  int checks = 0, failures = 0;
  bit finished = 0;
  logic [47:0] st48 = '0;
  logic [63:0] tbl = '0;

  always #4 clk = ~clk;

  addr_filter dut_i (.*);

  function automatic logic [5:0] model_hash(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < 48; i++) begin
      logic f = c[31] ^ a[i];
      c = c << 1;
      if (f) c = c ^ 32'h04C1_1DB7;
    end
    return c[31:26];
  endfunction

  function automatic logic model_accept(input logic [47:0] a);
    if (a[0]) return tbl[model_hash(a)];
    return a == st48;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    if (a < 6) st48[8*a +: 8] = d;
    else if (a >= 8) tbl[8*(a-8) +: 8] = d;
  endtask

  task automatic set_station(input logic [47:0] s);
    for (int k = 0; k < 6; k++) wr(4'(k), s[8*k +: 8]);
  endtask

  task automatic set_table(input logic [63:0] t);
    for (int m = 0; m < 8; m++) wr(4'(8 + m), t[8*m +: 8]);
  endtask

  // gaps: max idle cycles per bit; sofbit: offer a bit together with sof; extra: bits after DA47
  task automatic frame(input logic [47:0] a, input int gaps, input bit sofbit, input int extra, input string req);
    logic e;
    e = model_accept(a);
    sof = 1; bit_vld = sofbit; bit_in = ~a[0];
    @(negedge clk);
    sof = 0; bit_vld = 0;
    chk("R3", dec_accept, 1'b0);
    chk("R3", dec_mcast, 1'b0);
    for (int i = 0; i < 48; i++) begin
      if (gaps > 0) begin
        int g = $urandom_range(gaps, 0);
        for (int j = 0; j < g; j++) begin
          bit_vld = 0; bit_in = $urandom_range(1, 0);
          @(negedge clk);
          chk("R7", dec_vld, 1'b0);
        end
      end
      bit_vld = 1; bit_in = a[i];
      @(negedge clk);
      if (i < 47) chk("R7", dec_vld, 1'b0);
    end
    bit_vld = 0;
    chk("R7", dec_vld, 1'b1);
    chk(req, dec_accept, e);
    chk("R4", dec_mcast, a[0]);
    for (int x = 0; x < extra; x++) begin
      bit_vld = 1; bit_in = $urandom_range(1, 0);
      @(negedge clk);
    end
    bit_vld = 0;
    @(negedge clk);
    chk("R7", dec_vld, 1'b0);
    chk("R8", dec_accept, e);
    chk("R8", dec_mcast, a[0]);
  endtask

  initial begin
    repeat (2000000 / 8) @(posedge clk);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [47:0] s, a;
    int unsigned seed;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    chk("R1", dec_vld, 1'b0);
    chk("R1", dec_accept, 1'b0);
    chk("R1", dec_mcast, 1'b0);
    rst_n = 1;
    @(negedge clk);
    // R1: zero station accepts the all-zero address; zero table rejects multicast
    frame(48'h0, 0, 0, 0, "R1");
    frame(48'h0000_0000_0001, 0, 0, 0, "R1");

    s = 48'hA1B2_C3D4_E5F6;
    set_station(s);
    frame(s, 0, 0, 0, "R5");
    for (int k = 0; k < 6; k++) begin
      a = s; a[8*k + 3] = ~a[8*k + 3];
      frame(a, 0, 0, 0, "R5");
    end
    // R2: addresses 6 and 7 decode to nothing
    cfg_we = 1; cfg_addr = 4'd6; cfg_wdata = 8'hFF; @(negedge clk);
    cfg_addr = 4'd7; @(negedge clk); cfg_we = 0;
    frame(s, 0, 0, 0, "R2");

    // R6: only the hashed bit set, then only its neighbour
    a = 48'h5566_7788_9901;
    set_table(64'h0);
    set_table(64'h1 << model_hash(a));
    frame(a, 0, 0, 0, "R6");
    chk("R6", dec_accept, 1'b1);
    set_table(64'h1 << (6'(model_hash(a) + 6'd1)));
    frame(a, 0, 0, 0, "R6");
    chk("R6", dec_accept, 1'b0);
    // R3: bit offered with sof ignored; R8: trailing bits ignored
    frame(s, 0, 1, 5, "R3");
    frame(s, 2, 0, 9, "R8");

    // R9
    set_table('1);
    for (int n = 0; n < 10; n++) begin
      a = {$urandom, $urandom}; a[0] = 1;
      frame(a, 1, 0, 0, "R9");
    end

    // random mix with gaps (R10)
    for (int n = 0; n < 60; n++) begin
      if (n % 10 == 0) set_table({$urandom, $urandom});
      a = {$urandom, $urandom};
      if ($urandom_range(2, 0) == 0) begin
        a = s;
        if ($urandom_range(1, 0) == 1) a[$urandom_range(47, 1)] ^= 1'b1;
      end
      frame(a, 3, 0, 0, a[0] ? "R6" : "R10");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule